// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This controller manages a chip with one always-on region and two switchable regions: a processor region and a converter region. A single requested power mode selects which switchable regions are powered. On a mode change, each region affected is moved through a fixed power-down or power-up sequence. The sequence drives a two-stage power switch, where the stages are called "on" and "good". It waits for the acknowledge of each stage, isolates the region's outputs, and saves or restores processor state through a retention enable.

Each region has its own sequencer, and the two run in parallel. The top level arbitrates mode requests. A request that arrives during a sequence is held until that sequence completes. Each acknowledge wait is guarded by a timeout value supplied at an input; an expired wait causes a sticky fault. The block also applies the isolation clamps to the outputs each switchable region drives toward the rest of the chip. The current mode, a busy flag and the fault flag are reported.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After a synchronous reset the mode is run (code 0). All four switch enables are high, both isolation enables and the retention enable are low, and busy and err are low.
- R2: Mode codes are 0 = run (both regions on), 1 = converter-only sleep (processor off, converter on) and 2 = deep sleep (both off). Code 3 is ignored. `cur_mode` only ever shows a legal code.
- R3: A region powers down in this order, each step in a later cycle than the one before: isolation high, then retention high (processor only), then "good" enable low, then wait for the good acknowledge low, then "on" enable low, then wait for the on acknowledge low.
- R4: A region powers up in this order: "on" enable high, then wait for the on acknowledge, then "good" enable high, then wait for the good acknowledge, then retention low. Isolation goes low exactly one cycle after retention goes low.
- R5: The sequencer waits for acknowledges before it advances. "Good" rises only while the on acknowledge is high, and "on" falls only while the good acknowledge is low.
- R6: The processor outputs are 4 bits in the default build. While processor isolation is high, they read bits 1:0 high and bits 3:2 low. The converter outputs read all zeros while converter isolation is high. With isolation low, both pass their inputs unchanged.
- R7: A legal request made while busy is latched, and the latest one wins. It is started only after the running sequence completes, and `cur_mode` first shows the mode of the sequence that was running.
- R8: A request for the mode already in force causes no sequence. Busy stays low and the enables do not change.
- R9: If an acknowledge is not seen within the programmed timeout, err goes high and stays high until reset. Busy stays high, and the switch enables hold their values.
- R10: While a sequence runs, busy is high and `cur_mode` keeps the old mode. `cur_mode` takes the new mode only once every region has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| ack_tmo | input | TMO_W | Acknowledge timeout, in cycles |
| cpu_on_en | output | 1 | Processor switch stage 1 enable |
| cpu_on_ack | input | 1 | Processor stage 1 acknowledge |
| cpu_good_en | output | 1 | Processor switch stage 2 enable |
| cpu_good_ack | input | 1 | Processor stage 2 acknowledge |
| cpu_iso | output | 1 | Processor isolation enable |
| cpu_ret | output | 1 | Processor retention enable (rise saves, fall restores) |
| cnv_on_en | output | 1 | Converter switch stage 1 enable |
| cnv_on_ack | input | 1 | Converter stage 1 acknowledge |
| cnv_good_en | output | 1 | Converter switch stage 2 enable |
| cnv_good_ack | input | 1 | Converter stage 2 acknowledge |
| cnv_iso | output | 1 | Converter isolation enable |
| cpu_out_raw | input | CPU_OUT_W | Outputs driven by the processor region |
| cpu_out_iso | output | CPU_OUT_W | Processor outputs after the clamps |
| cnv_out_raw | input | CNV_OUT_W | Outputs driven by the converter region |
| cnv_out_iso | output | CNV_OUT_W | Converter outputs after the clamps |
| cur_mode | output | 2 | Mode currently in force |
| busy | output | 1 | Sequence running or request pending |
| err | output | 1 | Sticky acknowledge timeout |

## Verification
The bench builds the block with a 6-bit timeout field and the default 4-bit processor and 3-bit converter output groups. It programs a timeout of 20 cycles and models the acknowledges with delays of 3 and 5 cycles. Because the two regions answer with different delays, their sequences overlap without finishing together, and `cur_mode` is checked to wait for the slower one. Freezing the processor acknowledge model makes the fault reachable within a few dozen cycles. A short queued-request run shows the pending mode being taken over after completion.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam logic [1:0] MODE_RUN      = 2'd0;
  localparam logic [1:0] MODE_SLP_CONV = 2'd1;
  localparam logic [1:0] MODE_SLP_ALL  = 2'd2;

  typedef enum logic [3:0] {
    ST_UP, ST_ISO, ST_SAVE, ST_GD_DN, ST_ON_DN,
    ST_DOWN, ST_ON_UP, ST_GD_UP, ST_REST, ST_FAULT
  } dom_st_e;

  function automatic logic mode_ok(input logic [1:0] m);
    return (m == MODE_RUN) || (m == MODE_SLP_CONV) || (m == MODE_SLP_ALL);
  endfunction
endpackage

// File: rtl/pwr_iso_clamp.sv
module pwr_iso_clamp #(
  parameter int W = 4,
  parameter logic [W-1:0] HI_MASK = '0
) (
  input  logic         iso,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (HI_MASK[i]) begin : g_hi
      assign dout[i] = iso | din[i];
    end else begin : g_lo
      assign dout[i] = ~iso & din[i];
    end
  end
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_seq_pkg::*;
#(
  parameter bit HAS_RET = 1'b1,
  parameter int TMO_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_on,
  input  logic [TMO_W-1:0] tmo,
  input  logic             on_ack,
  input  logic             good_ack,
  output logic             on_en,
  output logic             good_en,
  output logic             iso_en,
  output logic             ret_en,
  output logic             settled,
  output logic             fault
);
  dom_st_e          st;
  logic [TMO_W-1:0] cnt;
  logic             tmo_hit;

  assign tmo_hit = (cnt == tmo);
  assign settled = ((st == ST_UP) && want_on) || ((st == ST_DOWN) && !want_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_UP;
      on_en   <= 1'b1;
      good_en <= 1'b1;
      iso_en  <= 1'b0;
      ret_en  <= 1'b0;
      cnt     <= '0;
      fault   <= 1'b0;
    end else begin
      case (st)
        ST_UP: if (!want_on) begin
          iso_en <= 1'b1;
          st     <= ST_ISO;
        end
        ST_ISO: begin
          ret_en <= HAS_RET ? 1'b1 : 1'b0;
          st     <= ST_SAVE;
        end
        ST_SAVE: begin
          good_en <= 1'b0;
          cnt     <= '0;
          st      <= ST_GD_DN;
        end
        ST_GD_DN: begin
          if (!good_ack) begin
            on_en <= 1'b0;
            cnt   <= '0;
            st    <= ST_ON_DN;
          end else if (tmo_hit) begin
            fault <= 1'b1;
            st    <= ST_FAULT;
          end else cnt <= cnt + 1'b1;
        end
        ST_ON_DN: begin
          if (!on_ack) st <= ST_DOWN;
          else if (tmo_hit) begin
            fault <= 1'b1;
            st    <= ST_FAULT;
          end else cnt <= cnt + 1'b1;
        end
        ST_DOWN: if (want_on) begin
          on_en <= 1'b1;
          cnt   <= '0;
          st    <= ST_ON_UP;
        end
        ST_ON_UP: begin
          if (on_ack) begin
            good_en <= 1'b1;
            cnt     <= '0;
            st      <= ST_GD_UP;
          end else if (tmo_hit) begin
            fault <= 1'b1;
            st    <= ST_FAULT;
          end else cnt <= cnt + 1'b1;
        end
        ST_GD_UP: begin
          if (good_ack) begin
            ret_en <= 1'b0;
            st     <= ST_REST;
          end else if (tmo_hit) begin
            fault <= 1'b1;
            st    <= ST_FAULT;
          end else cnt <= cnt + 1'b1;
        end
        ST_REST: begin
          iso_en <= 1'b0;
          st     <= ST_UP;
        end
        default: st <= ST_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int TMO_W     = 8,
  parameter int CPU_OUT_W = 4,
  parameter int CNV_OUT_W = 3,
  parameter logic [CPU_OUT_W-1:0] CPU_HI_MASK = 'b11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_mode,
  input  logic [TMO_W-1:0]     ack_tmo,
  output logic                 cpu_on_en,
  input  logic                 cpu_on_ack,
  output logic                 cpu_good_en,
  input  logic                 cpu_good_ack,
  output logic                 cpu_iso,
  output logic                 cpu_ret,
  output logic                 cnv_on_en,
  input  logic                 cnv_on_ack,
  output logic                 cnv_good_en,
  input  logic                 cnv_good_ack,
  output logic                 cnv_iso,
  input  logic [CPU_OUT_W-1:0] cpu_out_raw,
  output logic [CPU_OUT_W-1:0] cpu_out_iso,
  input  logic [CNV_OUT_W-1:0] cnv_out_raw,
  output logic [CNV_OUT_W-1:0] cnv_out_iso,
  output logic [1:0]           cur_mode,
  output logic                 busy,
  output logic                 err
);
  logic [1:0] tgt_q, cur_q, pend_q;
  logic       pend_v, idle, req_ok;
  logic       cpu_set, cnv_set, cpu_flt, cnv_flt, cnv_ret_unused;

  assign idle   = (tgt_q == cur_q);
  assign req_ok = req_valid && mode_ok(req_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= MODE_RUN;
      cur_q  <= MODE_RUN;
      pend_q <= MODE_RUN;
      pend_v <= 1'b0;
    end else begin
      if (!idle && cpu_set && cnv_set) cur_q <= tgt_q;
      if (idle) begin
        pend_v <= 1'b0;
        if (req_ok) begin
          if (req_mode != cur_q) tgt_q <= req_mode;
        end else if (pend_v && (pend_q != cur_q)) begin
          tgt_q <= pend_q;
        end
      end else if (req_ok) begin
        pend_q <= req_mode;
        pend_v <= 1'b1;
      end
    end
  end

  pwr_dom_seq #(.HAS_RET(1'b1), .TMO_W(TMO_W)) u_cpu (
    .clk(clk), .rst(rst), .want_on(tgt_q == MODE_RUN), .tmo(ack_tmo),
    .on_ack(cpu_on_ack), .good_ack(cpu_good_ack),
    .on_en(cpu_on_en), .good_en(cpu_good_en), .iso_en(cpu_iso),
    .ret_en(cpu_ret), .settled(cpu_set), .fault(cpu_flt));

  pwr_dom_seq #(.HAS_RET(1'b0), .TMO_W(TMO_W)) u_cnv (
    .clk(clk), .rst(rst), .want_on(tgt_q != MODE_SLP_ALL), .tmo(ack_tmo),
    .on_ack(cnv_on_ack), .good_ack(cnv_good_ack),
    .on_en(cnv_on_en), .good_en(cnv_good_en), .iso_en(cnv_iso),
    .ret_en(cnv_ret_unused), .settled(cnv_set), .fault(cnv_flt));

  pwr_iso_clamp #(.W(CPU_OUT_W), .HI_MASK(CPU_HI_MASK)) u_cpu_clamp (
    .iso(cpu_iso), .din(cpu_out_raw), .dout(cpu_out_iso));

  pwr_iso_clamp #(.W(CNV_OUT_W), .HI_MASK('0)) u_cnv_clamp (
    .iso(cnv_iso), .din(cnv_out_raw), .dout(cnv_out_iso));

  assign err      = cpu_flt | cnv_flt;
  assign cur_mode = cur_q;
  assign busy     = !idle || pend_v || err || cnv_ret_unused;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int CPU_OUT_W = 4,
  parameter int CNV_OUT_W = 3,
  parameter logic [CPU_OUT_W-1:0] CPU_HI_MASK = 'b11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cpu_on_en,
  input logic                 cpu_on_ack,
  input logic                 cpu_good_en,
  input logic                 cpu_good_ack,
  input logic                 cpu_iso,
  input logic                 cpu_ret,
  input logic                 cnv_on_en,
  input logic                 cnv_on_ack,
  input logic                 cnv_good_en,
  input logic                 cnv_good_ack,
  input logic                 cnv_iso,
  input logic [CPU_OUT_W-1:0] cpu_out_raw,
  input logic [CPU_OUT_W-1:0] cpu_out_iso,
  input logic [CNV_OUT_W-1:0] cnv_out_iso,
  input logic [1:0]           cur_mode,
  input logic                 busy,
  input logic                 err
);
  // R3
  cpu_good_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_good_en) |-> (cpu_iso && cpu_ret));
  // R3
  cnv_good_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_good_en) |-> cnv_iso);
  // R5
  cpu_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_on_en) |-> !cpu_good_ack);
  // R5
  cnv_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_on_en) |-> !cnv_good_ack);
  // R5
  cpu_good_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_good_en) |-> cpu_on_ack);
  // R5
  cnv_good_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_good_en) |-> cnv_on_ack);
  // R4
  iso_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_ret) |=> $fell(cpu_iso));
  // R6
  cpu_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_iso |-> (cpu_out_iso == CPU_HI_MASK));
  // R6
  cpu_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_iso |-> (cpu_out_iso == cpu_out_raw));
  // R6
  cnv_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    cnv_iso |-> (cnv_out_iso == '0));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && busy));
  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cur_mode != 2'd3);
  // R10
  idle_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && cur_mode == 2'd0) |-> (cpu_on_en && cpu_good_en && cnv_on_en && cnv_good_en));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
  .CPU_OUT_W(CPU_OUT_W), .CNV_OUT_W(CNV_OUT_W), .CPU_HI_MASK(CPU_HI_MASK)
) u_chk (
  .clk(clk), .rst(rst),
  .cpu_on_en(cpu_on_en), .cpu_on_ack(cpu_on_ack),
  .cpu_good_en(cpu_good_en), .cpu_good_ack(cpu_good_ack),
  .cpu_iso(cpu_iso), .cpu_ret(cpu_ret),
  .cnv_on_en(cnv_on_en), .cnv_on_ack(cnv_on_ack),
  .cnv_good_en(cnv_good_en), .cnv_good_ack(cnv_good_ack),
  .cnv_iso(cnv_iso),
  .cpu_out_raw(cpu_out_raw), .cpu_out_iso(cpu_out_iso),
  .cnv_out_iso(cnv_out_iso),
  .cur_mode(cur_mode), .busy(busy), .err(err)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW    = 6;
  localparam int P_DLY = 3;
  localparam int C_DLY = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [TW-1:0] ack_tmo = 6'd20;
  logic cpu_on_en, cpu_on_ack, cpu_good_en, cpu_good_ack, cpu_iso, cpu_ret;
  logic cnv_on_en, cnv_on_ack, cnv_good_en, cnv_good_ack, cnv_iso;
  logic [3:0] cpu_out_raw = 4'd0;
  logic [3:0] cpu_out_iso;
  logic [2:0] cnv_out_raw = 3'd0;
  logic [2:0] cnv_out_iso;
  logic [1:0] cur_mode;
  logic busy, err;
  logic cpu_stuck = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.TMO_W(TW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode), .ack_tmo(ack_tmo),
    .cpu_on_en(cpu_on_en), .cpu_on_ack(cpu_on_ack),
    .cpu_good_en(cpu_good_en), .cpu_good_ack(cpu_good_ack),
    .cpu_iso(cpu_iso), .cpu_ret(cpu_ret),
    .cnv_on_en(cnv_on_en), .cnv_on_ack(cnv_on_ack),
    .cnv_good_en(cnv_good_en), .cnv_good_ack(cnv_good_ack), .cnv_iso(cnv_iso),
    .cpu_out_raw(cpu_out_raw), .cpu_out_iso(cpu_out_iso),
    .cnv_out_raw(cnv_out_raw), .cnv_out_iso(cnv_out_iso),
    .cur_mode(cur_mode), .busy(busy), .err(err));

  // acknowledge models: each acknowledge follows its enable after a delay
  logic [P_DLY-1:0] p_on_sr, p_gd_sr;
  logic [C_DLY-1:0] c_on_sr, c_gd_sr;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      p_on_sr <= '1; p_gd_sr <= '1; c_on_sr <= '1; c_gd_sr <= '1;
    end else begin
      if (!cpu_stuck) begin
        p_on_sr <= {p_on_sr[P_DLY-2:0], cpu_on_en};
        p_gd_sr <= {p_gd_sr[P_DLY-2:0], cpu_good_en};
      end
      c_on_sr <= {c_on_sr[C_DLY-2:0], cnv_on_en};
      c_gd_sr <= {c_gd_sr[C_DLY-2:0], cnv_good_en};
    end
  end
  assign cpu_on_ack   = p_on_sr[P_DLY-1];
  assign cpu_good_ack = p_gd_sr[P_DLY-1];
  assign cnv_on_ack   = c_on_sr[C_DLY-1];
  assign cnv_good_ack = c_gd_sr[C_DLY-1];

  // event monitor on the processor region
  int t_iso_r, t_ret_r, t_gd_f, t_gack_f, t_on_f, t_onack_f;
  int t_on_r, t_onack_r, t_gd_r, t_gack_r, t_ret_f, t_iso_f;
  logic pv_iso, pv_ret, pv_gd, pv_gack, pv_on, pv_onack;
  always @(negedge clk) begin
    if (cpu_iso && !pv_iso && t_iso_r < 0) t_iso_r = cyc;
    if (!cpu_iso && pv_iso && t_iso_f < 0) t_iso_f = cyc;
    if (cpu_ret && !pv_ret && t_ret_r < 0) t_ret_r = cyc;
    if (!cpu_ret && pv_ret && t_ret_f < 0) t_ret_f = cyc;
    if (!cpu_good_en && pv_gd && t_gd_f < 0) t_gd_f = cyc;
    if (cpu_good_en && !pv_gd && t_gd_r < 0) t_gd_r = cyc;
    if (!cpu_good_ack && pv_gack && t_gack_f < 0) t_gack_f = cyc;
    if (cpu_good_ack && !pv_gack && t_gack_r < 0) t_gack_r = cyc;
    if (!cpu_on_en && pv_on && t_on_f < 0) t_on_f = cyc;
    if (cpu_on_en && !pv_on && t_on_r < 0) t_on_r = cyc;
    if (!cpu_on_ack && pv_onack && t_onack_f < 0) t_onack_f = cyc;
    if (cpu_on_ack && !pv_onack && t_onack_r < 0) t_onack_r = cyc;
    pv_iso = cpu_iso; pv_ret = cpu_ret; pv_gd = cpu_good_en;
    pv_gack = cpu_good_ack; pv_on = cpu_on_en; pv_onack = cpu_on_ack;
  end

  task automatic clr_events();
    t_iso_r = -1; t_ret_r = -1; t_gd_f = -1; t_gack_f = -1; t_on_f = -1; t_onack_f = -1;
    t_on_r = -1; t_onack_r = -1; t_gd_r = -1; t_gack_r = -1; t_ret_f = -1; t_iso_f = -1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_mode == 2'd0, "R1 mode", cur_mode, 0);
    chk({cpu_on_en, cpu_good_en, cnv_on_en, cnv_good_en} == 4'hF, "R1 enables",
        {cpu_on_en, cpu_good_en, cnv_on_en, cnv_good_en}, 15);
    chk({cpu_iso, cpu_ret, cnv_iso} == 3'b000, "R1 iso/ret", {cpu_iso, cpu_ret, cnv_iso}, 0);
    chk({busy, err} == 2'b00, "R1 busy/err", {busy, err}, 0);
    cpu_out_raw = 4'b0101; cnv_out_raw = 3'b101;
    #1;
    chk(cpu_out_iso == 4'b0101, "R6 cpu pass", cpu_out_iso, 5);
    chk(cnv_out_iso == 3'b101, "R6 cnv pass", cnv_out_iso, 5);
  endtask

  task automatic t_cpu_sleep();
    clr_events();
    send(2'd1);
    chk(busy == 1'b1, "R10 busy", busy, 1);
    chk(cur_mode == 2'd0, "R10 old mode", cur_mode, 0);
    wait_idle();
    chk(cur_mode == 2'd1, "R2 mode 1", cur_mode, 1);
    chk({cpu_on_en, cpu_good_en, cpu_iso, cpu_ret} == 4'b0011, "R2 cpu off",
        {cpu_on_en, cpu_good_en, cpu_iso, cpu_ret}, 3);
    chk({cnv_on_en, cnv_good_en, cnv_iso} == 3'b110, "R2 cnv on",
        {cnv_on_en, cnv_good_en, cnv_iso}, 6);
    chk(t_iso_r >= 0 && t_iso_r < t_ret_r && t_ret_r < t_gd_f, "R3 iso<ret<good", t_ret_r, t_iso_r + 1);
    chk(t_gd_f < t_gack_f && t_gack_f < t_on_f && t_on_f < t_onack_f, "R3 good<on", t_on_f, t_gack_f + 1);
    chk(t_on_f == t_gack_f + 1, "R5 on waits good ack", t_on_f, t_gack_f + 1);
    cpu_out_raw = 4'b0100;
    #1;
    chk(cpu_out_iso == 4'b0011, "R6 cpu clamp", cpu_out_iso, 3);
  endtask

  task automatic t_ignored();
    logic [3:0] en0;
    en0 = {cpu_on_en, cpu_good_en, cnv_on_en, cnv_good_en};
    send(2'd1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R8 same mode busy", busy, 0);
    chk({cpu_on_en, cpu_good_en, cnv_on_en, cnv_good_en} == en0, "R8 enables", en0, en0);
    send(2'd3);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && cur_mode == 2'd1, "R2 code 3 ignored", cur_mode, 1);
  endtask

  task automatic t_deep();
    send(2'd2);
    wait_idle();
    chk(cur_mode == 2'd2, "R2 mode 2", cur_mode, 2);
    chk({cnv_on_en, cnv_good_en, cnv_iso} == 3'b001, "R2 cnv off",
        {cnv_on_en, cnv_good_en, cnv_iso}, 1);
    cnv_out_raw = 3'b111;
    #1;
    chk(cnv_out_iso == 3'b000, "R6 cnv clamp", cnv_out_iso, 0);
  endtask

  task automatic t_wake();
    clr_events();
    send(2'd0);
    wait_idle();
    chk(cur_mode == 2'd0, "R2 mode 0", cur_mode, 0);
    chk({cpu_on_en, cpu_good_en, cnv_on_en, cnv_good_en, cpu_iso, cpu_ret, cnv_iso} == 7'b1111000,
        "R4 all on", {cpu_on_en, cpu_good_en, cnv_on_en, cnv_good_en, cpu_iso, cpu_ret, cnv_iso}, 120);
    chk(t_on_r >= 0 && t_on_r < t_onack_r && t_onack_r < t_gd_r, "R4 on<good", t_gd_r, t_onack_r + 1);
    chk(t_gd_r == t_onack_r + 1, "R5 good waits on ack", t_gd_r, t_onack_r + 1);
    chk(t_gack_r < t_ret_f, "R4 restore after good ack", t_ret_f, t_gack_r + 1);
    chk(t_iso_f == t_ret_f + 1, "R4 iso one cycle after ret", t_iso_f, t_ret_f + 1);
  endtask

  task automatic t_queued();
    send(2'd2);
    send(2'd1);
    for (int i = 0; i < 300 && cur_mode == 2'd0; i++) @(negedge clk);
    chk(cur_mode == 2'd2, "R7 first sequence", cur_mode, 2);
    chk(busy == 1'b1, "R7 pending keeps busy", busy, 1);
    wait_idle();
    chk(cur_mode == 2'd1, "R7 latched mode", cur_mode, 1);
    chk({cpu_on_en, cnv_on_en} == 2'b01, "R7 enables", {cpu_on_en, cnv_on_en}, 1);
  endtask

  task automatic t_timeout();
    cpu_stuck = 1'b1;
    send(2'd0);
    repeat (40) @(negedge clk);
    chk(err == 1'b1, "R9 err set", err, 1);
    chk(busy == 1'b1 && cur_mode == 2'd1, "R9 busy, mode kept", cur_mode, 1);
    chk({cpu_on_en, cpu_good_en} == 2'b10, "R9 enables held", {cpu_on_en, cpu_good_en}, 2);
    repeat (10) @(negedge clk);
    chk(err == 1'b1 && {cpu_on_en, cpu_good_en} == 2'b10, "R9 sticky", err, 1);
    cpu_stuck = 1'b0;
    cpu_out_raw = 4'b0000; cnv_out_raw = 3'b000;
    t_reset();
  endtask

  initial begin
    clr_events();
    t_reset();
    t_cpu_sleep();
    t_ignored();
    t_deep();
    t_wake();
    t_queued();
    t_timeout();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule